// File: doc/BRIEF.md
# Complementary Three-Phase PWM Timer

This block generates three complementary PWM output pairs with built-in non-overlap time, as used to drive the high and low switches of a three-phase bridge. Two up/down counters produce the same triangular carrier. The leading counter is preloaded with a margin T and the lagging counter starts from zero, so the leading carrier runs T count ticks ahead of the lagging one. Both counters advance on a shared count-enable input.

Each phase compares both carriers against its own duty value. The high-side output is on only while both carriers are at or above the duty. The low-side output is on only while both carriers are below it. The carriers differ by T ticks, so every handover between the two outputs of a pair has exactly T ticks with both outputs low.

Software writes the preloads, the period and the duties while the block is halted, then sets both start bits in a single write. At that start write the block checks the setup. A bad setup raises a sticky error flag and keeps every output low.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the start bits, the error flag and all six outputs are 0, and count-enable pulses do not start counting.
- R2: The register address map is: 0 = leading counter preload, 1 = lagging counter preload, 2 = period (carrier peak minus one), 3/4/5 = duty of phase 0/1/2, and 6 = start bits, where wr_data bit 0 starts the leading counter and bit 1 starts the lagging counter. Writes to addresses 0 to 5 take effect only while both start bits are 0. While the block runs they are ignored, and the waveform continues unchanged.
- R3: The counters advance only while both start bits are 1 and the error flag is 0. With only one start bit set, the counters keep their values and all outputs stay 0.
- R4: While running, each counter moves by one on every clock with cnt_en high and holds when cnt_en is low. It rises to period+1, then falls to 0, then rises again.
- R5: The leading counter, started from preload T, holds the same triangular sequence as the lagging counter, shifted T count ticks ahead.
- R6: While running, pwm_hi[i] is 1 exactly when both counters are at or above duty i. pwm_lo[i] is 1 exactly when both counters are below duty i.
- R7: pwm_hi[i] and pwm_lo[i] are never 1 together. When one of them falls and its partner rises next, the partner rises exactly T count ticks later.
- R8: Whenever the start bits are not both 1, all six outputs are 0.
- R9: Writing 1 to both start bits with a bad setup sets cfg_err. A setup is bad when the two preloads are equal, when a duty is below the leading preload, when a duty is above the period, or when the period is all ones. While cfg_err is set, all outputs stay 0 and the counters hold. cfg_err is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable tick shared by both counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (map in R2) |
| wr_data | input | CW | Register write data |
| pwm_hi | output | 3 | High-side output of each phase |
| pwm_lo | output | 3 | Low-side output of each phase |
| cfg_err | output | 1 | Sticky bad-setup flag |

## Verification
The counter-range and step assertions assume that a run starts from a legal setup. Under that assumption the leading preload stays below the peak and the period+1 peak cannot wrap. The R9 check guarantees this, because a run never begins while cfg_err is set. The stimulus keeps the lagging preload at 0 and picks duties no higher than about the peak minus T/2, so every handover in a pair happens and the T-tick gap can be measured. Configuration writes are made only at points where the rules say whether they must land or be ignored, and the reference carriers in the bench are computed from a closed-form triangle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int NPH = 3;

  typedef enum logic [2:0] {
    A_LEAD   = 3'd0,
    A_LAG    = 3'd1,
    A_PERIOD = 3'd2,
    A_DUTY0  = 3'd3,
    A_DUTY1  = 3'd4,
    A_DUTY2  = 3'd5,
    A_START  = 3'd6
  } cpwm_addr_e;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cpwm_dir_e;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [CW-1:0]            wr_data,
  output logic [1:0]               lead_lag_ld,
  output logic [CW-1:0]            period,
  output logic [NPH-1:0][CW-1:0]   duty,
  output logic [1:0]               start,
  output logic                     run,
  output logic                     err
);
  logic [CW-1:0]          lead_sh, lag_sh, period_q;
  logic [NPH-1:0][CW-1:0] duty_q;
  logic [1:0]             start_q;
  logic                   err_q;
  logic                   halted;
  logic                   start_wr, start_bad;

  function automatic logic setup_ok(input logic [CW-1:0] lead, input logic [CW-1:0] lag,
                                    input logic [CW-1:0] per,
                                    input logic [NPH-1:0][CW-1:0] d);
    logic ok;
    ok = (lead != lag) && (per != '1);
    for (int i = 0; i < NPH; i++)
      if (d[i] < lead || d[i] > per) ok = 1'b0;
    return ok;
  endfunction

  assign halted    = (start_q == 2'b00);
  assign start_wr  = wr_en && (cpwm_addr_e'(wr_addr) == A_START);
  assign start_bad = start_wr && (wr_data[1:0] == 2'b11) &&
                     !setup_ok(lead_sh, lag_sh, period_q, duty_q);

  assign lead_lag_ld[0] = wr_en && halted && (cpwm_addr_e'(wr_addr) == A_LEAD);
  assign lead_lag_ld[1] = wr_en && halted && (cpwm_addr_e'(wr_addr) == A_LAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_sh  <= '0;
      lag_sh   <= '0;
      period_q <= '0;
      duty_q   <= '0;
      start_q  <= 2'b00;
      err_q    <= 1'b0;
    end else if (wr_en) begin
      if (halted) begin
        if (cpwm_addr_e'(wr_addr) == A_LEAD)   lead_sh  <= wr_data;
        if (cpwm_addr_e'(wr_addr) == A_LAG)    lag_sh   <= wr_data;
        if (cpwm_addr_e'(wr_addr) == A_PERIOD) period_q <= wr_data;
        for (int i = 0; i < NPH; i++)
          if (int'(wr_addr) == int'(A_DUTY0) + i) duty_q[i] <= wr_data;
      end
      if (start_wr)  start_q <= wr_data[1:0];
      if (start_bad) err_q   <= 1'b1;
    end
  end

  assign period = period_q;
  assign duty   = duty_q;
  assign start  = start_q;
  assign err    = err_q;
  assign run    = (start_q == 2'b11) && !err_q;

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_period_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && wr_en && cpwm_addr_e'(wr_addr) == A_PERIOD) |=> $stable(period_q));
  assert_err_on_bad_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> err_q);
endmodule

// File: rtl/cpwm_updown.sv
module cpwm_updown
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          run,
  input  logic          ce,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt
);
  cpwm_dir_e     dir_q;
  logic [CW-1:0] cnt_q;
  logic          step_ev;

  function automatic logic [CW-1:0] next_cnt(input cpwm_dir_e d, input logic [CW-1:0] c);
    return (d == DIR_UP) ? c + 1'b1 : c - 1'b1;
  endfunction

  function automatic cpwm_dir_e next_dir(input cpwm_dir_e d, input logic [CW-1:0] c,
                                         input logic [CW-1:0] p);
    if (d == DIR_UP && c == p)   return DIR_DOWN;
    if (d == DIR_DOWN && c == 1) return DIR_UP;
    return d;
  endfunction

  assign step_ev = run && ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (ld) begin
      cnt_q <= ld_val;
      dir_q <= DIR_UP;
    end else if (step_ev) begin
      cnt_q <= next_cnt(dir_q, cnt_q);
      dir_q <= next_dir(dir_q, cnt_q, period);
    end
  end

  assign cnt = cnt_q;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ce) |=> $stable(cnt_q));
  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt_q} <= {1'b0, period} + 1'b1));
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] lead,
  input  logic [CW-1:0] lag,
  input  logic [CW-1:0] duty,
  output logic          hi,
  output logic          lo
);
  function automatic logic both_at_or_above(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                            input logic [CW-1:0] d);
    return (a >= d) && (b >= d);
  endfunction

  function automatic logic both_below(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                      input logic [CW-1:0] d);
    return (a < d) && (b < d);
  endfunction

  assign hi = run && both_at_or_above(lead, lag, duty);
  assign lo = run && both_below(lead, lag, duty);

  assert_pair_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo));
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [2:0]    pwm_hi,
  output logic [2:0]    pwm_lo,
  output logic          cfg_err
);
  logic [1:0]             ld;
  logic [CW-1:0]          period;
  logic [NPH-1:0][CW-1:0] duty;
  logic [1:0]             start;
  logic                   run;
  logic                   err;
  logic [1:0][CW-1:0]     cnt;

  cpwm_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lead_lag_ld(ld), .period(period), .duty(duty), .start(start), .run(run), .err(err)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cnt
    cpwm_updown #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld(ld[c]), .ld_val(wr_data), .run(run),
      .ce(cnt_en), .period(period), .cnt(cnt[c])
    );
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    cpwm_phase #(.CW(CW)) u_ph (
      .clk(clk), .rst_n(rst_n), .run(run), .lead(cnt[0]), .lag(cnt[1]),
      .duty(duty[p]), .hi(pwm_hi[p]), .lo(pwm_lo[p])
    );
  end

  assign cfg_err = err;

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start != 2'b11) |-> (pwm_hi == '0 && pwm_lo == '0));
  assert_err_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pwm_hi == '0 && pwm_lo == '0));
  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start != 2'b11 && cnt_en && !wr_en) |=> ($stable(cnt[0]) && $stable(cnt[1])));
endmodule

// File: tb/sim_cpwm_timer.sv
`timescale 1ns/1ps
module sim_cpwm_timer;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0]    pwm_hi, pwm_lo;
  logic          cfg_err;

  cpwm_timer #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         tick;
    logic [2:0] hi;
    logic [2:0] lo;
    bit         first;
  } item_t;
  item_t sb_q[$];

  int n_checks = 0, n_fail = 0, gap_checks = 0;
  int cur_t, cur_m, k;
  int d[3];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tri_pos(input int x, input int m);
    int r;
    r = x % (2 * m);
    return (r <= m) ? r : 2 * m - r;
  endfunction

  task automatic wr(input int a, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = CW'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // driver: one expected item per clock while running
  task automatic run_ticks(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      item_t it;
      int ld, lg, mn, mx;
      @(negedge clk);
      cnt_en = ((i % every) == 0);
      if (cnt_en) k++;
      ld = tri_pos(k + cur_t, cur_m);
      lg = tri_pos(k, cur_m);
      mn = (ld < lg) ? ld : lg;
      mx = (ld > lg) ? ld : lg;
      for (int p = 0; p < 3; p++) begin
        it.hi[p] = (mn >= d[p]);
        it.lo[p] = (mx < d[p]);
      end
      it.tick  = k;
      it.first = (i == 0);
      sb_q.push_back(it);
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  // monitor: compares after each edge, tracks pair handover gaps
  bit   fv[3];
  bit   fhi[3];
  int   ft[3];
  logic [2:0] ph, pl;
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(pwm_hi === it.hi, "R6", "pwm_hi", int'(pwm_hi), int'(it.hi));
      chk(pwm_lo === it.lo, "R6", "pwm_lo", int'(pwm_lo), int'(it.lo));
      chk((pwm_hi & pwm_lo) == 3'b000, "R7", "pair overlap", int'(pwm_hi & pwm_lo), 0);
      if (it.first) begin
        for (int p = 0; p < 3; p++) fv[p] = 1'b0;
      end else begin
        for (int p = 0; p < 3; p++) begin
          if (ph[p] && !pwm_hi[p]) begin fv[p] = 1'b1; fhi[p] = 1'b1; ft[p] = it.tick; end
          if (pl[p] && !pwm_lo[p]) begin fv[p] = 1'b1; fhi[p] = 1'b0; ft[p] = it.tick; end
          if (!pl[p] && pwm_lo[p] && fv[p] && fhi[p]) begin
            gap_checks++;
            chk(it.tick - ft[p] == cur_t, "R7", "gap hi->lo", it.tick - ft[p], cur_t);
          end
          if (!ph[p] && pwm_hi[p] && fv[p] && !fhi[p]) begin
            gap_checks++;
            chk(it.tick - ft[p] == cur_t, "R7", "gap lo->hi", it.tick - ft[p], cur_t);
          end
        end
      end
      ph = pwm_hi;
      pl = pwm_lo;
    end
  end

  task automatic chk_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
      chk(pwm_hi == 3'b000 && pwm_lo == 3'b000, req, "outputs low", int'({pwm_hi, pwm_lo}), 0);
    end
  endtask

  task automatic setup(input int t, input int lag, input int per, input int d0, input int d1, input int d2);
    wr(0, t); wr(1, lag); wr(2, per); wr(3, d0); wr(4, d1); wr(5, d2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(pwm_hi == 0 && pwm_lo == 0, "R1", "outputs after reset", int'({pwm_hi, pwm_lo}), 0);
    chk(cfg_err == 1'b0, "R1", "err after reset", int'(cfg_err), 0);
    chk_idle("R1", 3);

    // Config A: T=4, peak 40, continuous ticks (R4 R5 R6 R7)
    setup(4, 0, 39, 10, 20, 30);
    cur_t = 4; cur_m = 40; d = '{10, 20, 30}; k = 0;
    wr(6, 3);
    chk(cfg_err == 1'b0, "R9", "legal setup err", int'(cfg_err), 0);
    run_ticks(170, 1);
    // R2: writes while running are ignored
    wr(3, 25); wr(0, 9); wr(2, 10);
    run_ticks(90, 1);
    chk(gap_checks > 0, "R7", "gap events seen", gap_checks, 1);
    wr(6, 0);
    chk_idle("R8", 3);

    // Config B: T=2, peak 16, duty at T and at period, sparse ticks; single start bit first (R3)
    setup(2, 0, 15, 2, 8, 15);
    cur_t = 2; cur_m = 16; d = '{2, 8, 15}; k = 0;
    wr(6, 1);
    chk_idle("R3", 5);
    wr(6, 3);
    gap_checks = 0;
    run_ticks(120, 3);
    chk(gap_checks > 0, "R7", "gap events seen B", gap_checks, 1);
    wr(6, 0);
    chk_idle("R8", 2);

    // R9: equal preloads
    do_reset();
    setup(3, 3, 20, 5, 6, 7);
    wr(6, 3);
    chk(cfg_err == 1'b1, "R9", "equal preloads err", int'(cfg_err), 1);
    chk_idle("R9", 3);
    wr(6, 0);
    chk(cfg_err == 1'b1, "R9", "err sticky", int'(cfg_err), 1);
    do_reset();
    chk(cfg_err == 1'b0, "R1", "reset clears err", int'(cfg_err), 0);

    // R9: duty below leading preload
    setup(4, 0, 20, 3, 6, 7);
    wr(6, 3);
    chk(cfg_err == 1'b1, "R9", "duty below T err", int'(cfg_err), 1);
    do_reset();

    // R9: duty above period
    setup(4, 0, 20, 5, 6, 21);
    wr(6, 3);
    chk(cfg_err == 1'b1, "R9", "duty above period err", int'(cfg_err), 1);
    chk_idle("R9", 2);
    do_reset();

    // R9: all-ones period
    setup(4, 0, 16'hFFFF, 5, 6, 7);
    wr(6, 3);
    chk(cfg_err == 1'b1, "R9", "all-ones period err", int'(cfg_err), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule